// File: doc/BRIEF.md
# Sample-Rate Divider Word Encoder

This block turns a requested audio sample rate, given in hertz, into the 12-bit divider word for an on-chip clock generator fed from a 28.224 MHz reference. It also reports the rate the generator will actually produce once the divider has been quantized. It has a single sequential restoring divider. The divider runs two passes per request. The first pass finds the raw divider from the request. The second pass recomputes the achieved rate from the divider value that survives encoding.

Requests enter on a valid/ready pair. `req_ready` is high only while the block is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While a computation runs, `req_ready` is low and anything on `req_valid` is ignored. The result side has no back-pressure. `res_valid` pulses for exactly one cycle. The result fields then hold their values until the next accepted request, so a consumer may capture them on the pulse or at any later point before it sends a new request. The word is presented as a high byte and a low byte. Software-visible programming writes the high byte first and then the low byte.

Top module: `srate_div_encoder`

## Requirements
- R1: A request with rate below 6900 or above 219000 is rejected. `res_valid` and `res_err` are high immediately after the accepting edge, and both result bytes and `res_rate` are 0. Rates of exactly 6900 and 219000 are accepted.
- R2: For an accepted rate r, the raw divider is d = (56448000 / r − 1) / 2, with both divisions truncating.
- R3: When d < 0x100, the word is 0xC00 + d.
- R4: When 0x100 ≤ d < 0x200, the word is 0x800 + d.
- R5: When 0x200 ≤ d < 0x400, the word is the low 9 bits of d, and the top 3 word bits are zero.
- R6: When 0x400 ≤ d < 0x800, the word is 0x200 + ((d >> 1) & 0x1FF), and d loses bit 0.
- R7: When d ≥ 0x800, the word is 0x400 + ((d >> 2) & 0x1FF), and d loses its two low bits.
- R8: `res_rate` equals 28224000 / (d' + 1), where d' is d after the truncation of R6 or R7. `res_err` is 0 for an accepted rate.
- R9: `res_word_hi` carries word bits 11:8 in its low nibble, with its upper nibble zero. `res_word_lo` carries word bits 7:0.
- R10: For an accepted in-range request, `res_valid` pulses for one cycle, 66 clock edges after the accepting edge. `req_ready` stays low in between, and `req_valid` during that time has no effect on the result.
- R11: After reset, `req_ready` is 1, and `res_valid`, `res_err`, both result bytes and `res_rate` are 0.
- R12: After `res_valid`, all result outputs hold steady while no request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_rate | input | 32 | Requested sample rate in Hz |
| res_valid | output | 1 | One-cycle result pulse |
| res_err | output | 1 | Request rejected as out of range |
| res_word_hi | output | 8 | Divider word bits 11:8, zero-extended |
| res_word_lo | output | 8 | Divider word bits 7:0 |
| res_rate | output | 32 | Achieved rate in Hz |

## Verification
Requested rates are picked so that the raw divider falls into each of the five encoding bands. In the two upper bands, the achieved rate differs from the request only if the dropped low bits are really discarded before the second division. Rates of exactly the range limits and one hertz outside them separate an off-by-one compare from a correct one. Other tests check that values driven on `req_valid` while busy leave the result unchanged, that the outputs stay put after the pulse, and that the pulse arrives after exactly 66 edges.

// File: rtl/srate_pkg.sv
package srate_pkg;
  localparam int unsigned RATE_W = 32;
  localparam int unsigned WORD_W = 12;
  localparam int unsigned MANT_W = WORD_W - 3;

  localparam logic [RATE_W-1:0] REF_HZ     = 32'd28224000;
  localparam logic [RATE_W-1:0] REF_HZ_X2  = 32'd56448000;
  localparam logic [RATE_W-1:0] MIN_HZ     = 32'd6900;
  localparam logic [RATE_W-1:0] MAX_HZ     = 32'd219000;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_PASS1 = 2'd1,
    S_PASS2 = 2'd2
  } enc_state_t;
endpackage

// File: rtl/srate_rdiv.sv
module srate_rdiv #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, quo_q, dsr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W:0]       shifted, diff;
  logic [W-1:0]     rem_nxt, quo_nxt;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    diff    = shifted - {1'b0, dsr_q};
    if (!diff[W]) begin
      rem_nxt = diff[W-1:0];
      quo_nxt = {quo_q[W-2:0], 1'b1};
    end else begin
      rem_nxt = shifted[W-1:0];
      quo_nxt = {quo_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        quo_q <= dividend_i;
        dsr_q <= divisor_i;
        cnt_q <= CNT_W'(W);
      end else if (cnt_q != '0) begin
        rem_q <= rem_nxt;
        quo_q <= quo_nxt;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) done_o <= 1'b1;
      end
    end
  end

  assign quot_o = quo_q;

  // R10: the controller never restarts a division in flight
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (cnt_q == '0));

  // R10: completion strobe lasts one cycle
  a_r10_div_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/srate_word_enc.sv
module srate_word_enc
  import srate_pkg::*;
(
  input  logic [RATE_W-1:0] d_i,
  output logic [WORD_W-1:0] word_o,
  output logic [RATE_W-1:0] d_kept_o
);
  always_comb begin
    if (d_i < 32'h100) begin
      word_o   = {3'b110, d_i[MANT_W-1:0]};
      d_kept_o = d_i;
    end else if (d_i < 32'h200) begin
      word_o   = {3'b100, d_i[MANT_W-1:0]};
      d_kept_o = d_i;
    end else if (d_i < 32'h400) begin
      word_o   = {3'b000, d_i[MANT_W-1:0]};
      d_kept_o = d_i;
    end else if (d_i < 32'h800) begin
      word_o   = {3'b001, d_i[MANT_W:1]};
      d_kept_o = d_i & ~32'h1;
    end else begin
      word_o   = {3'b010, d_i[MANT_W+1:2]};
      d_kept_o = d_i & ~32'h3;
    end
  end

  // R7: truncation never raises the divider
  always_comb begin
    a_r7_kept_le: assert (d_kept_o <= d_i);
  end
endmodule

// File: rtl/srate_div_encoder.sv
module srate_div_encoder
  import srate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [RATE_W-1:0] req_rate,
  output logic              res_valid,
  output logic              res_err,
  output logic [7:0]        res_word_hi,
  output logic [7:0]        res_word_lo,
  output logic [RATE_W-1:0] res_rate
);
  enc_state_t        state_q;
  logic [WORD_W-1:0] word_q;
  logic              bad_rate, div_start, div_done;
  logic [RATE_W-1:0] div_dividend, div_divisor, div_quo;
  logic [RATE_W-1:0] d_raw, d_kept;
  logic [WORD_W-1:0] enc_word;

  assign req_ready = (state_q == S_IDLE);
  assign bad_rate  = (req_rate < MIN_HZ) || (req_rate > MAX_HZ);
  assign d_raw     = (div_quo - 32'd1) >> 1;

  always_comb begin
    div_start = 1'b0;
    if (state_q == S_IDLE && req_valid && !bad_rate) div_start = 1'b1;
    if (state_q == S_PASS1 && div_done)             div_start = 1'b1;
    if (state_q == S_IDLE) begin
      div_dividend = REF_HZ_X2;
      div_divisor  = req_rate;
    end else begin
      div_dividend = REF_HZ;
      div_divisor  = d_kept + 32'd1;
    end
  end

  srate_rdiv #(.W(RATE_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (div_start),
    .dividend_i (div_dividend),
    .divisor_i  (div_divisor),
    .done_o     (div_done),
    .quot_o     (div_quo)
  );

  srate_word_enc u_enc (
    .d_i      (d_raw),
    .word_o   (enc_word),
    .d_kept_o (d_kept)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      word_q    <= '0;
      res_rate  <= '0;
      res_err   <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          if (bad_rate) begin
            res_valid <= 1'b1;
            res_err   <= 1'b1;
            word_q    <= '0;
            res_rate  <= '0;
          end else begin
            res_err <= 1'b0;
            state_q <= S_PASS1;
          end
        end
        S_PASS1: if (div_done) begin
          word_q  <= enc_word;
          state_q <= S_PASS2;
        end
        S_PASS2: if (div_done) begin
          res_rate  <= div_quo;
          res_valid <= 1'b1;
          state_q   <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign res_word_hi = {{(16 - WORD_W){1'b0}}, word_q[WORD_W-1:8]};
  assign res_word_lo = word_q[7:0];

  // R10: result strobe is a single cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R1: a rejection carries zeroed results
  a_r1_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> (res_rate == '0 && word_q == '0));

  // R8: an accepted result lands near the legal band
  a_r8_rate_band: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err) |-> (res_rate >= 32'd6000 && res_rate <= 32'd230000));

  // R12: results stay put while idle without a request
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && !req_valid) |=> ($stable(res_rate) && $stable(word_q) && $stable(res_err)));
endmodule

// File: tb/srate_div_encoder_test.sv
module srate_div_encoder_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_rate = '0;
  logic        res_valid, res_err;
  logic [7:0]  res_word_hi, res_word_lo;
  logic [31:0] res_rate;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srate_div_encoder uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rate(req_rate), .res_valid(res_valid), .res_err(res_err),
    .res_word_hi(res_word_hi), .res_word_lo(res_word_lo), .res_rate(res_rate)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic void model(input int unsigned r, output int unsigned w,
                                output int unsigned ach);
    int unsigned q, d, dk;
    q = 56448000 / r;
    d = (q - 1) / 2;
    dk = d;
    if (d < 'h100)      w = 'hC00 + d;
    else if (d < 'h200) w = 'h800 + d;
    else if (d < 'h400) w = d & 'h1FF;
    else if (d < 'h800) begin w = 'h200 + ((d >> 1) & 'h1FF); dk = d & ~32'h1; end
    else                begin w = 'h400 + ((d >> 2) & 'h1FF); dk = d & ~32'h3; end
    ach = 28224000 / (dk + 1);
  endfunction

  // issues one request, returns edges from acceptance to result
  task automatic issue(input logic [31:0] r, output int lat);
    @(negedge clk);
    req_valid = 1'b1;
    req_rate  = r;
    chk("R10 ready before request", {31'd0, req_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!res_valid && lat < 200) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    if (lat >= 200) chk("R10 result timeout", 32'd0, 32'd1);
  endtask

  task automatic t_rate(input logic [31:0] r, input string tag);
    int lat;
    int unsigned w, ach;
    model(r, w, ach);
    issue(r, lat);
    chk({tag, " word hi"}, {24'd0, res_word_hi}, w >> 8);
    chk({tag, " word lo"}, {24'd0, res_word_lo}, w & 'hFF);
    chk({"R8 rate ", tag}, res_rate, ach);
    chk({"R8 err ", tag}, {31'd0, res_err}, 32'd0);
    chk({"R10 latency ", tag}, lat, 32'd66);
  endtask

  task automatic t_reject(input logic [31:0] r);
    int lat;
    issue(r, lat);
    chk("R1 err flag", {31'd0, res_err}, 32'd1);
    chk("R1 latency", lat, 32'd0);
    chk("R1 word", {16'd0, res_word_hi, res_word_lo}, 32'd0);
    chk("R1 rate", res_rate, 32'd0);
  endtask

  task automatic t_reset;
    chk("R11 ready", {31'd0, req_ready}, 32'd1);
    chk("R11 valid", {31'd0, res_valid}, 32'd0);
    chk("R11 err", {31'd0, res_err}, 32'd0);
    chk("R11 word", {16'd0, res_word_hi, res_word_lo}, 32'd0);
    chk("R11 rate", res_rate, 32'd0);
  endtask

  task automatic t_busy_ignore;
    int lat;
    int unsigned w, ach;
    model(48000, w, ach);
    @(negedge clk);
    req_valid = 1'b1; req_rate = 48000;
    @(posedge clk);
    @(negedge clk);
    req_rate = 8000;
    lat = 0;
    for (int i = 0; i < 20; i++) begin
      chk("R10 not ready while busy", {31'd0, req_ready}, 32'd0);
      @(posedge clk); lat++; @(negedge clk);
    end
    req_valid = 1'b0;
    while (!res_valid && lat < 200) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    chk("R10 busy latency", lat, 32'd66);
    chk("R10 busy ignored word", {16'd0, res_word_hi, res_word_lo}, w);
    chk("R10 busy ignored rate", res_rate, ach);
  endtask

  task automatic t_hold;
    logic [31:0] r0;
    logic [15:0] w0;
    r0 = res_rate;
    w0 = {res_word_hi, res_word_lo};
    @(posedge clk); @(negedge clk);
    chk("R10 pulse single", {31'd0, res_valid}, 32'd0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R12 rate hold", res_rate, r0);
    chk("R12 word hold", {16'd0, res_word_hi, res_word_lo}, {16'd0, w0});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_rate(192000, "R3 R9 192000");
    t_rate(219000, "R1 R3 upper limit");
    t_rate(96000,  "R4 96000");
    t_rate(48000,  "R5 R2 48000");
    t_rate(44100,  "R5 44100");
    t_rate(32000,  "R5 32000");
    t_hold();
    t_rate(22050,  "R6 22050");
    t_rate(8000,   "R7 8000");
    t_rate(6900,   "R1 R7 lower limit");
    t_reject(6899);
    t_reject(219001);
    t_reject(0);
    t_reject(32'hFFFF_FFFF);
    t_rate(11025,  "R7 after reject");
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule